// File: doc/BRIEF.md
# Stereo Codec and SRAM Frame Sequencer

This block runs one audio frame each time a sample-period strobe is seen. A frame is a full-duplex exchange of four serial bytes with an audio codec: it carries the left and right 16-bit playback samples out and brings the left and right captured samples in. Interleaved with that exchange, the block reads the next pair of playback samples from an external asynchronous SRAM and writes the pair just captured. The serial shifter is outside the block. The block hands it one byte at a time together with a load pulse, and it waits for a byte-done pulse before it loads the next byte.

The surrounding logic supplies the read and write word addresses for the frame. The left sample lives at the given address and the right sample at the next word. A caller that advances the write base by two words per frame therefore fills the buffer contiguously. Straight after reset, the block writes zero to every word of the memory in ascending order. A strobe that arrives during that clear pass, or during a running frame, is remembered and served as soon as the block is free.

Top module: `duplex_frame_seq`

## Requirements
- R1: After reset, and before any frame starts, every word address from 0 to 2^ADDR_W-1 is written exactly once with zero, in ascending order.
- R2: A frame loads four serial bytes in this order: high byte of the left playback sample, low byte of the left sample, high byte of the right sample, low byte of the right sample. The playback samples are those read in the previous frame, and both are zero before any frame has completed.
- R3: The byte received in each of the four slots is stored at the same position as the byte sent in that slot. The left captured sample {slot0, slot1} is written at the write base. The right captured sample {slot2, slot3} is written at the write base plus one.
- R4: The memory accesses of a frame follow this fixed order: read left at the read base, write left at the write base, read right at the read base plus one, write right at the write base plus one. The first three accesses are issued after loading the 2nd, 3rd and 4th serial byte respectively. The last access is issued after the 4th byte completes.
- R5: The read base plus one and the write base plus one wrap modulo 2^ADDR_W, so the all-ones address is followed by address 0.
- R6: The data bus is driven only during a write access. The bus is never driven while output enable is active. While write enable is low, chip enable is low, output enable is high and the bus is driven.
- R7: Write enable stays low for at least WE_LEN consecutive clocks, with address and data unchanged throughout. Write enable returns high at least one clock before the bus is released.
- R8: A serial byte is loaded only after the previous byte's done pulse. The load pulse lasts one clock. A frame starts only after the previous frame's last memory access has completed.
- R9: A strobe that arrives during the clear pass or during a running frame is held and starts one frame once the block is free. Several strobes that arrive while one is pending start only one frame.
- R10: The playback outputs take the two samples read in a frame once that frame's final write completes. They hold those values until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | Sample-period strobe |
| rd_base | input | ADDR_W | Read word address for the left sample |
| wr_base | input | ADDR_W | Write word address for the left sample |
| byte_done | input | 1 | Serial byte finished, one-clock pulse |
| rx_byte | input | SAMPLE_W/2 | Byte received in the finished slot |
| tx_byte | output | SAMPLE_W/2 | Byte to send in the current slot |
| tx_load | output | 1 | One-clock pulse that starts a serial byte |
| sram_addr | output | ADDR_W | Memory word address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_o | output | SAMPLE_W | Write data |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | SAMPLE_W | Read data from the memory |
| play_left | output | SAMPLE_W | Left sample to be sent in the next frame |
| play_right | output | SAMPLE_W | Right sample to be sent in the next frame |

## Verification
Three situations are hard to reach from the ports. The first is a read that must see a write made earlier in the same frame: this happens when the read base plus one equals the write base. The second is address wrap on the plus-one access. The third is a strobe that lands while the block is busy. The stimulus reaches all three on purpose. A small memory configuration keeps the clear pass short. One frame places the read base just below the write base, so the right read returns the left sample captured moments earlier. Other frames sit at the top of the address space, so the plus-one access wraps. The first strobe is issued during the clear pass, and bursts of strobes are issued in the middle of a frame, so that holding and collapsing pending strobes can be seen in the count of frames that follow.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

   // serial slots per frame: left hi, left lo, right hi, right lo
   localparam int SLOT_COUNT = 4;

   typedef enum logic [2:0] {
      SQ_CLR_GO,
      SQ_CLR_WAIT,
      SQ_IDLE,
      SQ_LOAD,
      SQ_WAIT,
      SQ_TAIL_GO,
      SQ_TAIL_WAIT
   } seq_state_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RD,
      PH_WSET,
      PH_WLOW,
      PH_WHOLD
   } mem_phase_e;

endpackage

// File: rtl/dfs_pending.sv
module dfs_pending (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic take,
   output logic pend
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= tick | (pend_q & ~take);
      end
   end

   assign pend = pend_q;

endmodule

// File: rtl/dfs_sram_port.sv
module dfs_sram_port #(
   parameter int ADDR_W  = 18,
   parameter int DATA_W  = 16,
   parameter int RD_WAIT = 2,
   parameter int WE_LEN  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   import dfs_pkg::*;

   localparam int CNT_MAX = (RD_WAIT > WE_LEN) ? RD_WAIT : WE_LEN;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_WAIT - 1);
   localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_LEN - 1);

   generate
      if (RD_WAIT < 1) begin : g_bad_rd
         $error("dfs_sram_port: RD_WAIT must be at least 1");
      end
      if (WE_LEN < 1) begin : g_bad_we
         $error("dfs_sram_port: WE_LEN must be at least 1");
      end
   endgenerate

   mem_phase_e        phase;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] rdata_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  addr_q <= addr;
                  data_q <= wdata;
                  cnt    <= '0;
                  phase  <= is_wr ? PH_WSET : PH_RD;
               end
            end
            PH_RD: begin
               if (cnt == RD_LAST) begin
                  rdata_q <= mem_dq_i;
                  done_q  <= 1'b1;
                  phase   <= PH_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_WSET: begin
               cnt   <= '0;
               phase <= PH_WLOW;
            end
            PH_WLOW: begin
               if (cnt == WE_LAST) begin
                  phase <= PH_WHOLD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_WHOLD: begin
               done_q <= 1'b1;
               phase  <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign done      = done_q;
   assign rdata     = rdata_q;
   assign mem_addr  = addr_q;
   assign mem_dq_o  = data_q;
   assign mem_ce_n  = (phase == PH_IDLE);
   assign mem_oe_n  = (phase != PH_RD);
   assign mem_we_n  = (phase != PH_WLOW);
   assign mem_dq_oe = (phase == PH_WSET) || (phase == PH_WLOW) || (phase == PH_WHOLD);

endmodule

// File: rtl/duplex_frame_seq.sv
module duplex_frame_seq #(
   parameter int ADDR_W   = 18,
   parameter int SAMPLE_W = 16,
   parameter int RD_WAIT  = 2,
   parameter int WE_LEN   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_tick,
   input  logic [ADDR_W-1:0]     rd_base,
   input  logic [ADDR_W-1:0]     wr_base,
   input  logic                  byte_done,
   input  logic [SAMPLE_W/2-1:0] rx_byte,
   output logic [SAMPLE_W/2-1:0] tx_byte,
   output logic                  tx_load,
   output logic [ADDR_W-1:0]     sram_addr,
   output logic                  sram_ce_n,
   output logic                  sram_oe_n,
   output logic                  sram_we_n,
   output logic [SAMPLE_W-1:0]   sram_dq_o,
   output logic                  sram_dq_oe,
   input  logic [SAMPLE_W-1:0]   sram_dq_i,
   output logic [SAMPLE_W-1:0]   play_left,
   output logic [SAMPLE_W-1:0]   play_right
);

   import dfs_pkg::*;

   localparam int BYTE_W = SAMPLE_W / 2;
   localparam int STEP_W = $clog2(SLOT_COUNT);
   localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SLOT_COUNT - 1);

   generate
      if ((SAMPLE_W % 2) != 0 || SAMPLE_W < 4) begin : g_bad_sample
         $error("duplex_frame_seq: SAMPLE_W must be even and at least 4");
      end
      if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_addr
         $error("duplex_frame_seq: ADDR_W out of range");
      end
   endgenerate

   seq_state_e        state;
   logic [STEP_W-1:0] step;
   logic [ADDR_W-1:0] rd_q;
   logic [ADDR_W-1:0] wr_q;
   logic [ADDR_W-1:0] clr_addr;
   logic [SAMPLE_W-1:0] fetch_l;
   logic [SAMPLE_W-1:0] fetch_r;
   logic [SAMPLE_W-1:0] play_l;
   logic [SAMPLE_W-1:0] play_r;
   logic              spi_ok;
   logic              mem_ok;

   // strobe holding
   logic pend;
   logic take;

   assign take = (state == SQ_IDLE) && pend;

   dfs_pending u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (frame_tick),
      .take  (take),
      .pend  (pend)
   );

   // memory access requests
   logic              mem_start;
   logic              mem_is_wr;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [SAMPLE_W-1:0] mem_req_data;
   logic              mem_done;
   logic [SAMPLE_W-1:0] mem_rdata;
   logic [ADDR_W-1:0] rd_next;
   logic [ADDR_W-1:0] wr_next;

   // per-slot byte storage
   logic [SLOT_COUNT-1:0][BYTE_W-1:0] cap;
   logic [SLOT_COUNT-1:0][BYTE_W-1:0] out_bytes;

   assign rd_next = rd_q + 1'b1;
   assign wr_next = wr_q + 1'b1;

   always_comb begin
      mem_start    = 1'b0;
      mem_is_wr    = 1'b0;
      mem_req_addr = '0;
      mem_req_data = '0;
      case (state)
         SQ_CLR_GO: begin
            mem_start    = 1'b1;
            mem_is_wr    = 1'b1;
            mem_req_addr = clr_addr;
         end
         SQ_TAIL_GO: begin
            mem_start    = 1'b1;
            mem_is_wr    = 1'b1;
            mem_req_addr = wr_next;
            mem_req_data = {cap[2], cap[3]};
         end
         SQ_LOAD: begin
            case (step)
               2'd1: begin
                  mem_start    = 1'b1;
                  mem_req_addr = rd_q;
               end
               2'd2: begin
                  mem_start    = 1'b1;
                  mem_is_wr    = 1'b1;
                  mem_req_addr = wr_q;
                  mem_req_data = {cap[0], cap[1]};
               end
               2'd3: begin
                  mem_start    = 1'b1;
                  mem_req_addr = rd_next;
               end
               default: mem_start = 1'b0;
            endcase
         end
         default: mem_start = 1'b0;
      endcase
   end

   dfs_sram_port #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (SAMPLE_W),
      .RD_WAIT (RD_WAIT),
      .WE_LEN  (WE_LEN)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (mem_start),
      .is_wr     (mem_is_wr),
      .addr      (mem_req_addr),
      .wdata     (mem_req_data),
      .done      (mem_done),
      .rdata     (mem_rdata),
      .mem_addr  (sram_addr),
      .mem_ce_n  (sram_ce_n),
      .mem_oe_n  (sram_oe_n),
      .mem_we_n  (sram_we_n),
      .mem_dq_o  (sram_dq_o),
      .mem_dq_oe (sram_dq_oe),
      .mem_dq_i  (sram_dq_i)
   );

   generate
      for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
         logic [BYTE_W-1:0] held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held <= '0;
            end else if (state == SQ_WAIT && byte_done && step == STEP_W'(s)) begin
               held <= rx_byte;
            end
         end
         assign cap[s] = held;
      end
   endgenerate

   assign out_bytes[0] = play_l[SAMPLE_W-1:BYTE_W];
   assign out_bytes[1] = play_l[BYTE_W-1:0];
   assign out_bytes[2] = play_r[SAMPLE_W-1:BYTE_W];
   assign out_bytes[3] = play_r[BYTE_W-1:0];

   assign tx_byte = out_bytes[step];
   assign tx_load = (state == SQ_LOAD);

   logic spi_seen;
   logic mem_seen;

   assign spi_seen = spi_ok | byte_done;
   assign mem_seen = mem_ok | mem_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_CLR_GO;
         step     <= '0;
         rd_q     <= '0;
         wr_q     <= '0;
         clr_addr <= '0;
         fetch_l  <= '0;
         fetch_r  <= '0;
         play_l   <= '0;
         play_r   <= '0;
         spi_ok   <= 1'b0;
         mem_ok   <= 1'b0;
      end else begin
         case (state)
            SQ_CLR_GO: begin
               state <= SQ_CLR_WAIT;
            end
            SQ_CLR_WAIT: begin
               if (mem_done) begin
                  if (&clr_addr) begin
                     state <= SQ_IDLE;
                  end else begin
                     clr_addr <= clr_addr + 1'b1;
                     state    <= SQ_CLR_GO;
                  end
               end
            end
            SQ_IDLE: begin
               if (pend) begin
                  rd_q  <= rd_base;
                  wr_q  <= wr_base;
                  step  <= '0;
                  state <= SQ_LOAD;
               end
            end
            SQ_LOAD: begin
               spi_ok <= 1'b0;
               mem_ok <= (step == '0);
               state  <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (byte_done) begin
                  spi_ok <= 1'b1;
               end
               if (mem_done) begin
                  mem_ok <= 1'b1;
                  if (step == 2'd1) fetch_l <= mem_rdata;
                  if (step == 2'd3) fetch_r <= mem_rdata;
               end
               if (spi_seen && mem_seen) begin
                  if (step == STEP_LAST) begin
                     state <= SQ_TAIL_GO;
                  end else begin
                     step  <= step + 1'b1;
                     state <= SQ_LOAD;
                  end
               end
            end
            SQ_TAIL_GO: begin
               state <= SQ_TAIL_WAIT;
            end
            SQ_TAIL_WAIT: begin
               if (mem_done) begin
                  play_l <= fetch_l;
                  play_r <= fetch_r;
                  state  <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign play_left  = play_l;
   assign play_right = play_r;

endmodule

// File: rtl/duplex_frame_seq_chk.sv
module duplex_frame_seq_chk #(
   parameter int ADDR_W   = 18,
   parameter int SAMPLE_W = 16,
   parameter int WE_LEN   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tx_load,
   input logic                byte_done,
   input logic [ADDR_W-1:0]   sram_addr,
   input logic                sram_ce_n,
   input logic                sram_oe_n,
   input logic                sram_we_n,
   input logic [SAMPLE_W-1:0] sram_dq_o,
   input logic                sram_dq_oe
);

   logic        in_flight;
   logic [15:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_flight <= 1'b0;
         low_run   <= '0;
      end else begin
         if (tx_load) in_flight <= 1'b1;
         else if (byte_done) in_flight <= 1'b0;
         if (!sram_we_n) low_run <= (low_run == 16'hFFFF) ? low_run : low_run + 1'b1;
         else low_run <= '0;
      end
   end

   // R6
   bus_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> !sram_dq_oe);

   // R6
   we_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (sram_dq_oe && !sram_ce_n && sram_oe_n));

   // R7
   we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_o)));

   // R7
   release_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_dq_oe) |-> $past(sram_we_n));

   // R7
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (int'(low_run) >= WE_LEN));

   // R8
   one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> !in_flight);

   // R8
   load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load);

endmodule

bind duplex_frame_seq duplex_frame_seq_chk #(
   .ADDR_W   (ADDR_W),
   .SAMPLE_W (SAMPLE_W),
   .WE_LEN   (WE_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_load    (tx_load),
   .byte_done  (byte_done),
   .sram_addr  (sram_addr),
   .sram_ce_n  (sram_ce_n),
   .sram_oe_n  (sram_oe_n),
   .sram_we_n  (sram_we_n),
   .sram_dq_o  (sram_dq_o),
   .sram_dq_oe (sram_dq_oe)
);

// File: tb/tb_duplex_frame_seq.sv
`timescale 1ns/1ps
module tb_duplex_frame_seq;

   localparam int AW    = 5;
   localparam int SW    = 16;
   localparam int BW    = SW / 2;
   localparam int WORDS = 1 << AW;
   localparam int LAT   = 6;
   localparam int LIMIT = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_tick = 1'b0;
   logic [AW-1:0] rd_base = '0;
   logic [AW-1:0] wr_base = '0;
   logic          byte_done = 1'b0;
   logic [BW-1:0] rx_byte = '0;
   logic [BW-1:0] tx_byte;
   logic          tx_load;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [SW-1:0] sram_dq_o;
   logic [SW-1:0] sram_dq_i;
   logic [SW-1:0] play_left, play_right;

   always #2.5 clk = ~clk;

   duplex_frame_seq #(.ADDR_W(AW), .SAMPLE_W(SW), .RD_WAIT(2), .WE_LEN(2)) dut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .rd_base(rd_base), .wr_base(wr_base),
      .byte_done(byte_done), .rx_byte(rx_byte),
      .tx_byte(tx_byte), .tx_load(tx_load),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
      .sram_dq_i(sram_dq_i), .play_left(play_left), .play_right(play_right)
   );

   // memory model, event log, serial model
   logic [SW-1:0] sram [WORDS];
   bit            sram_ready = 1'b0;
   int            ev_type [512];   // 0 tx, 1 read, 2 write
   int            ev_a [512];
   int            ev_d [512];
   int            ev_n = 0;
   int            spi_cnt = 0;
   int            rx_idx = 0;
   int            cyc = 0;
   logic          prev_ce = 1'b1;

   assign sram_dq_i = (!sram_ce_n && !sram_oe_n) ? sram[sram_addr] : 16'hDEAD;

   function automatic logic [SW-1:0] cap_sample(int f, int ch);
      return SW'(f * 16'h0391 + ch * 16'h5A3C + 16'h1E07);
   endfunction

   function automatic logic [BW-1:0] rx_val(int k);
      logic [SW-1:0] smp;
      smp = cap_sample(k / 4, (k % 4) / 2);
      return ((k % 2) == 0) ? smp[SW-1:BW] : smp[BW-1:0];
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (!sram_ready) begin
         for (int i = 0; i < WORDS; i++) sram[i] = 16'hA5A5;
         sram_ready = 1'b1;
      end
      if (!sram_we_n && !sram_ce_n && sram_dq_oe) sram[sram_addr] = sram_dq_o;
      if (tx_load && ev_n < 512) begin
         ev_type[ev_n] = 0; ev_a[ev_n] = 0; ev_d[ev_n] = int'(tx_byte); ev_n++;
      end
      if (!sram_ce_n && prev_ce && ev_n < 512) begin
         ev_type[ev_n] = !sram_oe_n ? 1 : 2;
         ev_a[ev_n] = int'(sram_addr);
         ev_d[ev_n] = int'(sram_dq_o);
         ev_n++;
      end
      prev_ce = sram_ce_n;
      byte_done = 1'b0;
      if (tx_load) begin
         spi_cnt = LAT;
      end else if (spi_cnt > 0) begin
         spi_cnt--;
         if (spi_cnt == 0) begin
            byte_done = 1'b1;
            rx_byte = rx_val(rx_idx);
            rx_idx++;
         end
      end
   end

   int n_chk = 0;
   int n_err = 0;
   bit timed_out = 1'b0;

   task automatic chk(bit ok, string req, int act, int exp, string what);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_events(int n);
      while (ev_n < n && cyc < LIMIT) @(negedge clk);
      if (ev_n < n && !timed_out) begin
         timed_out = 1'b1;
         chk(1'b0, "R8", ev_n, n, "watchdog expired waiting for events");
      end
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
   endtask

   // bench-side expectation
   logic [SW-1:0] exp_mem [WORDS];
   logic [SW-1:0] exp_pl = '0;
   logic [SW-1:0] exp_pr = '0;

   task automatic chk_ev(int idx, int typ, int a, int d, string req, string what);
      chk(ev_type[idx] == typ, req, ev_type[idx], typ, {what, " kind"});
      if (typ == 0) chk(ev_d[idx] == d, req, ev_d[idx], d, {what, " tx byte"});
      else chk(ev_a[idx] == a, req, ev_a[idx], a, {what, " address"});
      if (typ == 2) chk(ev_d[idx] == d, "R3", ev_d[idx], d, {what, " write data"});
   endtask

   task automatic check_frame(int f, int rd, int wr);
      int b;
      int rdn;
      int wrn;
      logic [SW-1:0] cl;
      logic [SW-1:0] cr;
      logic [SW-1:0] rl;
      logic [SW-1:0] rr;
      b   = WORDS + 8 * f;
      rdn = (rd + 1) % WORDS;   // R5 wrap
      wrn = (wr + 1) % WORDS;
      cl  = cap_sample(f, 0);
      cr  = cap_sample(f, 1);
      // R2 byte order of previous samples
      chk_ev(b + 0, 0, 0, int'(exp_pl[SW-1:BW]), "R2", "slot0");
      chk_ev(b + 1, 0, 0, int'(exp_pl[BW-1:0]),  "R2", "slot1");
      // R4 access order
      chk_ev(b + 2, 1, rd, 0, "R4", "read left");
      chk_ev(b + 3, 0, 0, int'(exp_pr[SW-1:BW]), "R2", "slot2");
      chk_ev(b + 4, 2, wr, int'(cl), "R4", "write left");
      chk_ev(b + 5, 0, 0, int'(exp_pr[BW-1:0]),  "R2", "slot3");
      chk_ev(b + 6, 1, rdn, 0, "R5", "read right");
      chk_ev(b + 7, 2, wrn, int'(cr), "R5", "write right");
      rl = exp_mem[rd];
      exp_mem[wr] = cl;
      rr = exp_mem[rdn];
      exp_mem[wrn] = cr;
      exp_pl = rl;
      exp_pr = rr;
   endtask

   task automatic check_quiet(int exp_ev);
      repeat (14) @(negedge clk);
      chk(ev_n == exp_ev, "R9", ev_n, exp_ev, "no extra frame started");
      chk(play_left == exp_pl, "R10", int'(play_left), int'(exp_pl), "left playback");
      chk(play_right == exp_pr, "R10", int'(play_right), int'(exp_pr), "right playback");
      chk(!sram_dq_oe && sram_we_n, "R6", int'(sram_dq_oe), 0, "bus released when idle");
   endtask

   task automatic run_frame(int f, int rd, int wr);
      rd_base = AW'(rd);
      wr_base = AW'(wr);
      pulse_tick();
      wait_events(WORDS + 8 * (f + 1));
      repeat (3) @(negedge clk);
      chk(play_left == exp_pl, "R10", int'(play_left), int'(exp_pl), "playback held during frame");
      check_frame(f, rd, wr);
      check_quiet(WORDS + 8 * (f + 1));
   endtask

   initial begin
      for (int i = 0; i < WORDS; i++) exp_mem[i] = '0;
      repeat (4) @(negedge clk);
      // reset state
      chk(sram_ce_n && sram_we_n && !sram_dq_oe, "R6", int'(sram_dq_oe), 0, "memory idle in reset");
      chk(!tx_load, "R8", int'(tx_load), 0, "no load in reset");
      chk(play_left == '0 && play_right == '0, "R2", int'(play_left), 0, "playback zero in reset");
      rst_n = 1'b1;
      // R9: strobe during clear pass
      rd_base = AW'(3);
      wr_base = AW'(10);
      pulse_tick();
      wait_events(WORDS + 8);
      // R1: clear pass
      for (int i = 0; i < WORDS; i++) begin
         chk(ev_type[i] == 2 && ev_a[i] == i && ev_d[i] == 0, "R1",
             ev_a[i], i, "clear write");
      end
      check_frame(0, 3, 10);
      check_quiet(WORDS + 8);
      // readback of frame 0 captures
      run_frame(1, 10, 12);
      // wrap at the top of the address space
      run_frame(2, 31, 30);
      // right read sees left write of the same frame, write wraps
      run_frame(3, 30, 31);
      // R9: strobes during a busy frame collapse into one
      rd_base = AW'(0);
      wr_base = AW'(2);
      pulse_tick();
      repeat (3) @(negedge clk);
      pulse_tick();
      repeat (2) @(negedge clk);
      pulse_tick();
      wait_events(WORDS + 8 * 6);
      check_frame(4, 0, 2);
      check_frame(5, 0, 2);   // R8 second frame only after the first
      repeat (30) @(negedge clk);
      check_quiet(WORDS + 8 * 6);
      // sweep of bases
      for (int i = 0; i < 8; i++) begin
         int wr;
         wr = (2 * i + 14) % WORDS;
         run_frame(6 + i, (wr + WORDS - 6) % WORDS, wr);
      end
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule